// File: doc/BRIEF.md
# Staggered 128-to-16 Lane Stream Reducer

This block accepts a stream of 128-bit words and turns it into a stream of 16-bit words, emitted two per core clock. It suits a fast output port that must be fed from a wide, bursty source. Each input word enters a small synchronous buffer. The word at the head of that buffer is then cut into eight 16-bit lanes. The lanes sit in four groups of two, and each group has its own holding register. A rotating four-phase controller loads one group per clock, so each group register changes exactly once every four clocks.

Two 4-to-1 selectors walk through the groups in the same rotation, three clocks behind the loads. Every group register has therefore been still for three clocks before it is sampled, which gives its outputs a relaxed multicycle path. The selected pair is registered as an "A" word and a "B" word with a valid strobe. A dual-edge output stage downstream sends A in the first half of the clock and B in the second.

Upstream flow control is a single high-watermark flag from the input buffer. A frame is four clocks long and moves out one whole 128-bit word. It starts only if a word is waiting when group 0's turn comes. Otherwise the whole frame is skipped and valid stays low for its four clocks, so a partial word is never emitted.

Top module: `qlane_stream_top`

## Requirements
- R1: While reset is held, and in the cycle it is released, `outValid` and `hiMark` are low and every group register is cleared.
- R2: The input buffer holds 16 words. A word is written when `inValid` is high and the buffer is not full. A word offered while the buffer holds 16 words is dropped and never appears at the output.
- R3: `hiMark` is high exactly when the buffer holds 12 or more words, counting the state after the most recent clock edge.
- R4: Lane i of a 128-bit word is bits [16i+15:16i]. Lanes 2k and 2k+1 belong to group k, and lane 2k goes to the A selector while lane 2k+1 goes to the B selector.
- R5: One frame emits the eight lanes of one word over four consecutive cycles, as the pairs (lane 0, lane 1), (2, 3), (4, 5) and (6, 7). The lower-numbered lane of each pair is on `outWordA` and the higher-numbered lane is on `outWordB`.
- R6: A frame starts only in a cycle of phase 0 where the buffer is not empty. If the buffer is empty then, no group is loaded, no word is taken, and `outValid` stays low for the four output cycles of that frame.
- R7: The first pair of a frame appears on the outputs four cycles after the phase-0 cycle in which group 0 is loaded. The other three pairs follow in the next three cycles.
- R8: Groups load in the fixed order 0, 1, 2, 3, one per cycle, and each group loads at most once in any four cycles.
- R9: A group is selected exactly three cycles after it was loaded, and it is not reloaded in the two cycles between the load and the selection.
- R10: `outValid` rises and falls only at frame boundaries, in cycles of phase 0.
- R11: The phase counter is 0 in the first cycle after reset is released and then steps 0, 1, 2, 3, 0 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Offer `inWord` to the input buffer in this cycle |
| inWord | input | 128 | Wide input word, made of eight 16-bit lanes |
| hiMark | output | 1 | Buffer holds 12 or more words; the source should pause |
| outValid | output | 1 | `outWordA` and `outWordB` carry a valid pair |
| outWordA | output | 16 | Word for the first half of the output cycle |
| outWordB | output | 16 | Word for the second half of the output cycle |

## Verification
The assertions assume that `hiMark` can rise only after a write was offered. They also assume that the select lag stays at three clocks, which matches four groups. The stimulus honours the watermark in one stretch and deliberately ignores it in another, so that it fills the buffer past 16 and exercises the drop rule. Sparse writes leave the buffer empty at some phase-0 cycles, so skipped frames fall between live ones. The reference model in the bench follows the rotation from the release of reset and predicts every output pair and the watermark on every cycle.

// File: rtl/qlane_pkg.sv
package qlane_pkg;
  localparam int GRP_N      = 4;
  localparam int GRP_IDX_W  = $clog2(GRP_N);
  localparam int LANES_PER  = 2;
  localparam int LANE_N     = GRP_N * LANES_PER;

  typedef struct packed {
    logic [GRP_N-1:0]     load;
    logic                 pop;
    logic [GRP_IDX_W-1:0] selIdx;
    logic                 selLive;
  } laneStrobes_t;
endpackage

// File: rtl/qlane_fifo.sv
module qlane_fifo #(
  parameter int WORD_W   = 128,
  parameter int DEPTH    = 16,
  parameter int HI_LEVEL = 12,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushReq,
  input  logic [WORD_W-1:0] pushWord,
  input  logic              popReq,
  output logic [WORD_W-1:0] headWord,
  output logic              empty,
  output logic              hiMark,
  output logic [CW-1:0]     fill
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic              pushOk, popOk;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    pushOk = pushReq && (count != CW'(DEPTH));
    popOk  = popReq && (count != '0);
  end

  always_ff @(posedge clk) begin
    if (pushOk) store[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= bump(wrPtr);
      if (popOk)  rdPtr <= bump(rdPtr);
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  assign headWord = store[rdPtr];
  assign empty    = (count == '0);
  assign hiMark   = (count >= CW'(HI_LEVEL));
  assign fill     = count;
endmodule

// File: rtl/qlane_ctrl.sv
module qlane_ctrl
  import qlane_pkg::*;
#(
  parameter int SEL_LAG = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bufEmpty,
  output laneStrobes_t         strb,
  output logic [GRP_IDX_W-1:0] phase
);
  localparam logic [GRP_IDX_W-1:0] LAST_PH = GRP_IDX_W'(GRP_N - 1);

  logic                                frameLive;
  logic                                liveNow;
  logic [SEL_LAG-1:0][GRP_IDX_W-1:0]   lagIdx;
  logic [SEL_LAG-1:0]                  lagLive;

  // A frame is committed at phase 0 and held for the remaining phases.
  always_comb liveNow = (phase == '0) ? !bufEmpty : frameLive;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      frameLive <= 1'b0;
    end else begin
      phase <= (phase == LAST_PH) ? '0 : phase + GRP_IDX_W'(1);
      if (phase == '0) frameLive <= !bufEmpty;
    end
  end

  // Select delay line: the group loaded now is chosen SEL_LAG clocks later.
  always_ff @(posedge clk) begin
    if (rst) begin
      lagIdx  <= '0;
      lagLive <= '0;
    end else begin
      for (int s = SEL_LAG - 1; s > 0; s--) begin
        lagIdx[s]  <= lagIdx[s-1];
        lagLive[s] <= lagLive[s-1];
      end
      lagIdx[0]  <= phase;
      lagLive[0] <= liveNow;
    end
  end

  always_comb begin
    strb.load    = liveNow ? (GRP_N'(1) << phase) : '0;
    strb.pop     = liveNow && (phase == LAST_PH);
    strb.selIdx  = lagIdx[SEL_LAG-1];
    strb.selLive = lagLive[SEL_LAG-1];
  end
endmodule

// File: rtl/qlane_datapath.sv
module qlane_datapath
  import qlane_pkg::*;
#(
  parameter int LANE_W     = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int HI_LEVEL   = 12,
  localparam int WORD_W = LANE_W * LANE_N,
  localparam int FILL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pushReq,
  input  logic [WORD_W-1:0] pushWord,
  input  laneStrobes_t      strb,
  output logic              bufEmpty,
  output logic              hiMark,
  output logic [FILL_W-1:0] fill,
  output logic              outValid,
  output logic [LANE_W-1:0] outWordA,
  output logic [LANE_W-1:0] outWordB
);
  logic [WORD_W-1:0] headWord;
  logic [LANE_W-1:0] laneOf [LANE_N];
  logic [LANE_W-1:0] grpA   [GRP_N];
  logic [LANE_W-1:0] grpB   [GRP_N];

  qlane_fifo #(
    .WORD_W  (WORD_W),
    .DEPTH   (FIFO_DEPTH),
    .HI_LEVEL(HI_LEVEL)
  ) u_buf (
    .clk     (clk),
    .rst     (rst),
    .pushReq (pushReq),
    .pushWord(pushWord),
    .popReq  (strb.pop),
    .headWord(headWord),
    .empty   (bufEmpty),
    .hiMark  (hiMark),
    .fill    (fill)
  );

  for (genvar i = 0; i < LANE_N; i++) begin : g_lane
    assign laneOf[i] = headWord[i*LANE_W +: LANE_W];
  end

  // Group k holds lanes 2k (A side) and 2k+1 (B side).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GRP_N; g++) begin
        grpA[g] <= '0;
        grpB[g] <= '0;
      end
    end else begin
      for (int g = 0; g < GRP_N; g++) begin
        if (strb.load[g]) begin
          grpA[g] <= laneOf[LANES_PER*g];
          grpB[g] <= laneOf[LANES_PER*g + 1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outWordA <= '0;
      outWordB <= '0;
    end else begin
      outValid <= strb.selLive;
      outWordA <= grpA[strb.selIdx];
      outWordB <= grpB[strb.selIdx];
    end
  end
endmodule

// File: rtl/qlane_stream_top.sv
module qlane_stream_top
  import qlane_pkg::*;
#(
  parameter int LANE_W     = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int HI_LEVEL   = 12,
  parameter int SEL_LAG    = 3,
  localparam int WORD_W = LANE_W * LANE_N,
  localparam int FILL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              hiMark,
  output logic              outValid,
  output logic [LANE_W-1:0] outWordA,
  output logic [LANE_W-1:0] outWordB
);
  laneStrobes_t         strb;
  logic [GRP_IDX_W-1:0] phase;
  logic [FILL_W-1:0]    fill;
  logic                 bufEmpty;

  qlane_ctrl #(.SEL_LAG(SEL_LAG)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .bufEmpty(bufEmpty),
    .strb    (strb),
    .phase   (phase)
  );

  qlane_datapath #(
    .LANE_W    (LANE_W),
    .FIFO_DEPTH(FIFO_DEPTH),
    .HI_LEVEL  (HI_LEVEL)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .pushReq (inValid),
    .pushWord(inWord),
    .strb    (strb),
    .bufEmpty(bufEmpty),
    .hiMark  (hiMark),
    .fill    (fill),
    .outValid(outValid),
    .outWordA(outWordA),
    .outWordB(outWordB)
  );
endmodule

// File: rtl/qlane_checker.sv
module qlane_checker
  import qlane_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int FILL_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 inValid,
  input logic                 hiMark,
  input logic                 outValid,
  input laneStrobes_t         strb,
  input logic [GRP_IDX_W-1:0] phase,
  input logic [FILL_W-1:0]    fill
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_W'(DEPTH));

  a_r3_mark_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(hiMark) |-> $past(inValid));

  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    strb.pop |-> (fill != '0));

  a_r8_one_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.load));

  for (genvar k = 0; k < GRP_N - 1; k++) begin : g_rot
    a_r8_rotation: assert property (@(posedge clk) disable iff (rst)
      strb.load[k] |=> strb.load[k+1]);
  end

  // Three-clock lag: selection of group k sees a load exactly three cycles back
  for (genvar k = 0; k < GRP_N; k++) begin : g_lag
    a_r9_select_lag: assert property (@(posedge clk) disable iff (rst)
      (strb.selLive && strb.selIdx == GRP_IDX_W'(k)) |->
        (!strb.load[k] && !$past(strb.load[k]) &&
         !$past(strb.load[k], 2) && $past(strb.load[k], 3)));
  end

  a_r10_rise_at_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> (phase == '0));

  a_r10_fall_at_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(outValid) |-> (phase == '0));

  a_r11_phase_steps: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (phase == $past(phase) + GRP_IDX_W'(1)));
endmodule

bind qlane_stream_top qlane_checker #(
  .DEPTH (FIFO_DEPTH),
  .FILL_W(FILL_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .hiMark  (hiMark),
  .outValid(outValid),
  .strb    (strb),
  .phase   (phase),
  .fill    (fill)
);

// File: tb/tb_qlane_stream_top.sv
module tb_qlane_stream_top;
  localparam int CLK_NS = 20;
  localparam int MAXC   = 1024;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [127:0] inWord = '0;
  logic         hiMark, outValid;
  logic [15:0]  outWordA, outWordB;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int seqNo  = 0;

  logic [127:0] q[$];
  logic         expV [MAXC];
  logic [15:0]  expA [MAXC];
  logic [15:0]  expB [MAXC];
  logic         frameOn = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  qlane_stream_top dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .hiMark(hiMark), .outValid(outValid),
    .outWordA(outWordA), .outWordB(outWordB)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [127:0] mk(input int n);
    logic [127:0] w;
    for (int i = 0; i < 8; i++) w[16*i +: 16] = {n[7:0], i[7:0]};
    return w;
  endfunction

  // Check the current cycle, drive inputs for it, model the coming edge.
  task automatic step(input logic pv);
    int p, sz;
    logic [127:0] w;
    check("R6 R7 R10 R11 outValid", {31'd0, outValid}, {31'd0, expV[cyc]});
    if (expV[cyc]) begin
      check("R4 R5 R8 R9 outWordA", {16'd0, outWordA}, {16'd0, expA[cyc]});
      check("R4 R5 R8 R9 outWordB", {16'd0, outWordB}, {16'd0, expB[cyc]});
    end
    check("R2 R3 hiMark", {31'd0, hiMark}, {31'd0, (q.size() >= 12)});
    w = mk(seqNo);
    inValid = pv;
    inWord  = w;
    if (pv) seqNo++;
    p  = cyc % 4;
    sz = q.size();
    if (p == 0) begin
      frameOn = (sz > 0);
      if (frameOn && cyc + 8 < MAXC) begin
        for (int j = 0; j < 4; j++) begin
          expV[cyc+4+j] = 1'b1;
          expA[cyc+4+j] = q[0][32*j +: 16];
          expB[cyc+4+j] = q[0][32*j+16 +: 16];
        end
      end
    end
    if (frameOn && p == 3) void'(q.pop_front());
    if (pv && sz < 16) q.push_back(w);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      expV[i] = 1'b0; expA[i] = '0; expB[i] = '0;
    end
    repeat (3) begin
      @(negedge clk);
      check("R1 outValid in reset", {31'd0, outValid}, 32'd0);
      check("R1 hiMark in reset", {31'd0, hiMark}, 32'd0);
    end
    rst = 1'b0;
    // R1 R6: idle after reset, nothing to send
    repeat (8) step(1'b0);
    // single word, then drain (R4 R5 R7)
    step(1'b1);
    repeat (12) step(1'b0);
    // watermark ignored: overfill so words are dropped (R2 R3)
    repeat (30) step(1'b1);
    repeat (90) step(1'b0);
    // flow controlled by the watermark
    repeat (60) step(!hiMark);
    // sparse writes leave phase-0 gaps (R6 R10)
    for (int i = 0; i < 48; i++) step(i % 7 == 0);
    repeat (70) step(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule